// File: doc/BRIEF.md
# Masked Wake Qualifier

This block sits in an always-on domain and turns an external wake request into a power-on request for a processor that is asleep. The wake request only counts once it has stayed high, without a break, for a programmable number of clock cycles. The default count equals 8 ms at a 125 MHz clock. When the count completes, the block raises its power-on output and gives a one-cycle wake pulse.

A domain-alive mask input comes from the processor's I/O supply. It goes high when software resume begins and falls only when that supply collapses late in hardware power-off. While the mask is high, the wake input is treated as low. A request that arrives during an unfinished power-down therefore cannot start a new power-on sequence. After the mask drops, the full qualification time must still pass.

Once power-on is high, further wake activity has no effect. Only a power-off command brings the output low again. The wake input and the mask are asynchronous and pass through a synchronizer. The power-off command is synchronous to the clock.

Top module: `wake_gate_top`

## Requirements
- R1: With the mask low and two synchronizer stages, a wake input that rises before clock edge k and stays high makes `pwr_on_o` read high after edge k+QUAL_CYCLES+1, and low after every earlier edge.
- R2: While the synchronized mask is high, the wake input is treated as low. Qualification progress is cleared, so `pwr_on_o` stays low however long the wake input is held high.
- R3: While `pwr_on_o` is high, changes on the wake input have no effect. `pwr_on_o` stays high and no wake pulse is produced.
- R4: A power-off command sampled high at a clock edge makes `pwr_on_o` low after that edge. In the same cycle it takes priority over a completing qualification.
- R5: If the wake input drops before the count completes, the count restarts from zero. A later request needs the full QUAL_CYCLES of continuous high samples.
- R6: `wake_pulse_o` is high for exactly one cycle, and that cycle is the first cycle in which `pwr_on_o` is high.
- R7: After a synchronous reset, `pwr_on_o` and `wake_pulse_o` are low and the qualification count is zero.
- R8: A wake input that is already high when the mask falls still waits the full count. It is measured from the mask release, with the same latency as R1 counted from the mask's falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req_i | input | 1 | Asynchronous external wake request, active high |
| io_alive_i | input | 1 | Asynchronous domain-alive mask; high blocks the wake input |
| pwr_off_i | input | 1 | Synchronous power-off command, active high |
| pwr_on_o | output | 1 | Registered power-on request to the processor |
| wake_pulse_o | output | 1 | One-cycle pulse on the rising edge of `pwr_on_o` |

## Verification
The hardest situation to reach from the ports is a wake request that is already high and steady when the mask falls. This is the late request that arrives during power-down. The stimulus first powers the processor on. It then raises the mask, issues power-off with the wake input still held high, and keeps the mask up for several qualification periods to show nothing happens. Finally it releases the mask. The release must start a fresh full-length count, and this is checked on the exact edge before and at the rise. An interrupted count one sample short of completion is also driven, to confirm the restart.

// File: rtl/wake_gate_pkg.sv
package wake_gate_pkg;

  typedef enum logic {
    PS_DOWN = 1'b0,
    PS_UP   = 1'b1
  } pwr_state_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wg_qualifier.sv
module wg_qualifier #(
  parameter int unsigned QUAL_CYCLES = 1_000_000,
  localparam int unsigned QW = wake_gate_pkg::cnt_bits(QUAL_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          hold_clr_i,
  output logic [QW-1:0] cnt_o,
  output logic          qual_o
);

  localparam logic [QW-1:0] LAST = QW'(QUAL_CYCLES - 1);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !req_i || hold_clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign qual_o = req_i && !hold_clr_i && (cnt_q == LAST);

endmodule

// File: rtl/wg_power_reg.sv
module wg_power_reg
  import wake_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic qual_i,
  input  logic off_i,
  output logic on_o,
  output logic pulse_o
);

  pwr_state_e state_q;
  logic       pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_DOWN;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (off_i) begin
        state_q <= PS_DOWN;
      end else if (qual_i && state_q == PS_DOWN) begin
        state_q <= PS_UP;
        pulse_q <= 1'b1;
      end
    end
  end

  assign on_o    = (state_q == PS_UP);
  assign pulse_o = pulse_q;

endmodule

// File: rtl/wake_gate_top.sv
module wake_gate_top #(
  parameter int unsigned QUAL_CYCLES = 1_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned QW = wake_gate_pkg::cnt_bits(QUAL_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_req_i,
  input  logic io_alive_i,
  input  logic pwr_off_i,
  output logic pwr_on_o,
  output logic wake_pulse_o
);

  logic [1:0]    sync_q;
  logic          wake_s;
  logic          mask_s;
  logic          eff_req;
  logic          qual;
  logic [QW-1:0] cnt_q;

  wg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({io_alive_i, wake_req_i}),
    .q_o (sync_q)
  );

  assign wake_s  = sync_q[0];
  assign mask_s  = sync_q[1];
  assign eff_req = wake_s && !mask_s;

  wg_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .req_i      (eff_req),
    .hold_clr_i (pwr_on_o),
    .cnt_o      (cnt_q),
    .qual_o     (qual)
  );

  wg_power_reg u_pwr (
    .clk     (clk),
    .rst     (rst),
    .qual_i  (qual),
    .off_i   (pwr_off_i),
    .on_o    (pwr_on_o),
    .pulse_o (wake_pulse_o)
  );

endmodule

// File: rtl/wake_gate_chk.sv
module wake_gate_chk #(
  parameter int unsigned QUAL_CYCLES = 1_000_000,
  parameter int unsigned QW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          wake_s,
  input logic          mask_s,
  input logic          pwr_off_i,
  input logic          pwr_on_o,
  input logic          wake_pulse_o,
  input logic [QW-1:0] cnt_q
);

  localparam int unsigned RW = $clog2(QUAL_CYCLES + 1);
  localparam logic [RW-1:0] FULL = RW'(QUAL_CYCLES);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !(wake_s && !mask_s && !pwr_on_o)) run_q <= '0;
    else if (run_q != FULL)                       run_q <= run_q + 1'b1;
  end

  AST_RISE_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_on_o) |-> (run_q == FULL)); // R1

  AST_MASK_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    mask_s |=> (cnt_q == '0)); // R2

  AST_ON_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pwr_on_o && !pwr_off_i) |=> pwr_on_o); // R3

  AST_OFF_DROPS: assert property (@(posedge clk) disable iff (rst)
    pwr_off_i |=> !pwr_on_o); // R4

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse_o |-> (pwr_on_o && !$past(pwr_on_o))); // R6

  AST_RISE_HAS_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_on_o) |-> wake_pulse_o); // R6

  AST_NO_COUNT_WHILE_ON: assert property (@(posedge clk) disable iff (rst)
    pwr_on_o |=> (cnt_q == '0)); // R3

endmodule

bind wake_gate_top wake_gate_chk #(.QUAL_CYCLES(QUAL_CYCLES), .QW(QW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wake_s       (wake_s),
  .mask_s       (mask_s),
  .pwr_off_i    (pwr_off_i),
  .pwr_on_o     (pwr_on_o),
  .wake_pulse_o (wake_pulse_o),
  .cnt_q        (cnt_q)
);

// File: tb/sim_wake_gate_top.sv
module sim_wake_gate_top;

  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_req_i = 1'b0;
  logic io_alive_i = 1'b0;
  logic pwr_off_i = 1'b0;
  logic pwr_on_o;
  logic wake_pulse_o;

  always #4 clk = ~clk;

  wake_gate_top #(.QUAL_CYCLES(Q), .SYNC_STAGES(2)) u0 (
    .clk          (clk),
    .rst          (rst),
    .wake_req_i   (wake_req_i),
    .io_alive_i   (io_alive_i),
    .pwr_off_i    (pwr_off_i),
    .pwr_on_o     (pwr_on_o),
    .wake_pulse_o (wake_pulse_o)
  );

  typedef struct {
    int    at;
    logic  on;
    logic  pl;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int at, input logic on, input logic pl, input string req);
    exp_t e;
    e.at = at; e.on = on; e.pl = pl; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares outputs against queued expectations at negedges
  always @(negedge clk) begin
    if (!done) begin
      while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (e.at < cyc) begin
          errors++;
          $display("FAIL %s: check for cycle %0d missed (actual cycle %0d, expected cycle %0d)",
                   e.req, e.at, cyc, e.at);
        end else if (pwr_on_o !== e.on || wake_pulse_o !== e.pl) begin
          errors++;
          $display("FAIL %s: cycle %0d on/pulse actual=%b/%b expected=%b/%b",
                   e.req, cyc, pwr_on_o, wake_pulse_o, e.on, e.pl);
        end
      end
      if (cyc > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int c;
    wait_cyc(3);
    rst = 1'b0;
    c = cyc;
    expect_at(c + 1, 1'b0, 1'b0, "R7 reset state");
    wait_cyc(3);

    // R1 / R6: basic qualification latency
    c = cyc;
    wake_req_i = 1'b1;
    expect_at(c + Q + 1, 1'b0, 1'b0, "R1 low one edge early");
    expect_at(c + Q + 2, 1'b1, 1'b1, "R1 R6 rise with pulse");
    expect_at(c + Q + 3, 1'b1, 1'b0, "R6 pulse single cycle");
    wait_cyc(Q + 5);

    // R4: power-off clears, then wake low
    c = cyc;
    pwr_off_i = 1'b1;
    wake_req_i = 1'b0;
    expect_at(c + 1, 1'b0, 1'b0, "R4 off clears");
    wait_cyc(1);
    pwr_off_i = 1'b0;
    wait_cyc(4);

    // R5: break one sample short of completion
    c = cyc;
    wake_req_i = 1'b1;
    expect_at(c + Q + 2, 1'b0, 1'b0, "R5 short run no rise");
    expect_at(c + Q + 4, 1'b0, 1'b0, "R5 short run still low");
    wait_cyc(Q - 1);
    wake_req_i = 1'b0;
    wait_cyc(8);
    c = cyc;
    wake_req_i = 1'b1;
    expect_at(c + Q + 1, 1'b0, 1'b0, "R5 full count restarted");
    expect_at(c + Q + 2, 1'b1, 1'b1, "R5 R1 rise after restart");
    expect_at(c + Q + 3, 1'b1, 1'b0, "R6 pulse ends");
    wait_cyc(Q + 5);

    // R3: wake activity ignored while on
    c = cyc;
    expect_at(c + 4, 1'b1, 1'b0, "R3 wake low ignored");
    expect_at(c + 9, 1'b1, 1'b0, "R3 new edge ignored");
    expect_at(c + Q + 8, 1'b1, 1'b0, "R3 still on no pulse");
    wake_req_i = 1'b0;
    wait_cyc(3);
    wake_req_i = 1'b1;
    wait_cyc(2);
    wake_req_i = 1'b0;
    wait_cyc(2);
    wake_req_i = 1'b1;
    wait_cyc(Q + 6);

    // resume then power-off with mask up and wake held high
    io_alive_i = 1'b1;
    wait_cyc(4);
    c = cyc;
    pwr_off_i = 1'b1;
    expect_at(c + 1, 1'b0, 1'b0, "R4 off with mask up");
    wait_cyc(1);
    pwr_off_i = 1'b0;

    // R2: mask blocks long held wake
    c = cyc;
    expect_at(c + Q + 5, 1'b0, 1'b0, "R2 masked wake ignored");
    expect_at(c + 3 * Q, 1'b0, 1'b0, "R2 masked wake long");
    wait_cyc(3 * Q + 2);

    // R8: mask release with wake already high waits full count
    c = cyc;
    io_alive_i = 1'b0;
    expect_at(c + Q + 1, 1'b0, 1'b0, "R8 no early rise");
    expect_at(c + Q + 2, 1'b1, 1'b1, "R8 rise after full count");
    expect_at(c + Q + 3, 1'b1, 1'b0, "R8 R6 pulse ends");
    wait_cyc(Q + 6);

    // R7: reset while on
    rst = 1'b1;
    wait_cyc(2);
    c = cyc;
    expect_at(c, 1'b0, 1'b0, "R7 reset drops on");
    wait_cyc(1);
    rst = 1'b0;
    wake_req_i = 1'b0;
    wait_cyc(3);

    while (exp_q.size() > 0) wait_cyc(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule